// File: doc/BRIEF.md
# SPI FIFO and Status Flag Unit

This block sits between a bus-side register interface and the shift register of an SPI controller. It holds a four-entry transmit FIFO filled by push writes and drained one word at a time whenever the shift register loads a command. It also holds a four-entry receive FIFO filled by completed frames and emptied by pop reads. Entry counters and the next-entry pointers of both FIFOs are exposed for status reads.

Around the receive path it keeps three flags. The drain flag asks software or a DMA engine to empty the receive FIFO. The sticky overflow flag records a transfer that began while both the FIFO and the shift register held unread data. The sticky parity flag records any frame reported with a parity error. A frame that completes while the receive FIFO is full stays in the shift register and moves into the FIFO on the next pop. While a word is held there, further incoming frames are dropped and the stored contents are kept.

All state changes on the rising clock edge. Outputs show the updated state after that edge.

Top module: `spi_fifo_status`

## Requirements
- R1: A push write (`push_we`) with `tx_cnt` below 4 stores `push_data` and raises `tx_cnt` by one. A push write while `tx_cnt` is 4 is ignored.
- R2: `tx_load` with `tx_cnt` above 0 lowers `tx_cnt` by one and advances `tx_nxt_ptr` by one modulo 4. `tx_head` always shows the entry at `tx_nxt_ptr`, so words leave in push order. A load with an empty FIFO is ignored. A push and a load in the same cycle leave `tx_cnt` unchanged.
- R3: `rx_done` with `rx_cnt` below 4 and no word held in the shift register stores `rx_data` and raises `rx_cnt` by one.
- R4: A pop read (`pop_re`) with `rx_cnt` above 0 presents the oldest entry on `pop_data` after the clock edge, advances `rx_pop_ptr` by one modulo 4 and lowers `rx_cnt` by one. A pop read while `rx_cnt` is 0 leaves `pop_data`, `rx_pop_ptr` and `rx_cnt` unchanged.
- R5: When `rx_done` and a valid pop occur in the same cycle, `rx_cnt` is unchanged.
- R6: `rx_done` while `rx_cnt` is 4 and no pop occurs keeps the word in the shift register. The next pop moves that word into the FIFO, so `rx_cnt` stays 4. While a word is held, further `rx_done` words are discarded.
- R7: `ovf_flag` sets when `xfer_start` occurs while `rx_cnt` is 4 and a word is held in the shift register. It then stays set until a status write (`sts_we`) with `sts_wdata` bit 1 set. A set condition wins over a clear in the same cycle.
- R8: `par_flag` sets when `rx_done` arrives with `rx_parity_err` high. It then stays set until a status write with `sts_wdata` bit 2 set. A set condition wins over a clear in the same cycle.
- R9: `drain_flag` is 1 whenever `rx_cnt` is above 0. Once the FIFO is empty, the flag stays 1 until either a status write with `sts_wdata` bit 0 set or `dma_ack` occurs in a cycle that leaves `rx_cnt` at 0. A clear attempt while entries remain has no effect.
- R10: After reset, all counters, pointers, flags, `tx_head` and `pop_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_we | input | 1 | Push write strobe into transmit FIFO |
| push_data | input | 32 | Word to push |
| tx_load | input | 1 | Shift register takes the next transmit entry |
| tx_head | output | 32 | Transmit entry at the next pointer |
| rx_done | input | 1 | Received frame complete strobe |
| rx_data | input | 32 | Received word |
| rx_parity_err | input | 1 | Received frame had a parity error |
| xfer_start | input | 1 | A new transfer begins |
| pop_re | input | 1 | Pop read strobe |
| pop_data | output | 32 | Last popped word |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 3 | Write-one-to-clear: bit0 drain, bit1 overflow, bit2 parity |
| dma_ack | input | 1 | DMA acknowledge |
| tx_cnt | output | 3 | Transmit FIFO entries |
| tx_nxt_ptr | output | 2 | Transmit entry sent next |
| rx_cnt | output | 3 | Receive FIFO entries |
| rx_pop_ptr | output | 2 | Receive entry returned by next pop |
| drain_flag | output | 1 | Receive drain request |
| ovf_flag | output | 1 | Sticky receive overflow |
| par_flag | output | 1 | Sticky parity error |

## Verification
Every output is a register output or a direct read of one. The result of any strobe is therefore due exactly one rising edge after that strobe is sampled, including the popped word and flag clears. The bench changes inputs just after a falling edge and compares all outputs at the next falling edge, half a period after the edge that captured them. The reference model is advanced at that same point, using the inputs that were held across the edge. Each cycle is thus judged against exactly one model step.

// File: rtl/spi_fifo_status.sv
module spi_fifo_status #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_we,
  input  logic [DATA_W-1:0]            push_data,
  input  logic                         tx_load,
  output logic [DATA_W-1:0]            tx_head,
  input  logic                         rx_done,
  input  logic [DATA_W-1:0]            rx_data,
  input  logic                         rx_parity_err,
  input  logic                         xfer_start,
  input  logic                         pop_re,
  output logic [DATA_W-1:0]            pop_data,
  input  logic                         sts_we,
  input  logic [2:0]                   sts_wdata,
  input  logic                         dma_ack,
  output logic [$clog2(DEPTH+1)-1:0]   tx_cnt,
  output logic [$clog2(DEPTH)-1:0]     tx_nxt_ptr,
  output logic [$clog2(DEPTH+1)-1:0]   rx_cnt,
  output logic [$clog2(DEPTH)-1:0]     rx_pop_ptr,
  output logic                         drain_flag,
  output logic                         ovf_flag,
  output logic                         par_flag
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [DATA_W-1:0] rx_mem [DEPTH];
  logic [PTR_W-1:0]  tx_wr_ptr, rx_wr_ptr;
  logic [DATA_W-1:0] hold_data;
  logic              hold_q;

  logic push_ok, load_ok, pop_ok, rx_full, rx_in, hold_set;
  logic [DATA_W-1:0] rx_wdata;
  logic [CNT_W-1:0]  rx_cnt_n;

  assign push_ok  = push_we && tx_cnt != FULL;
  assign load_ok  = tx_load && tx_cnt != '0;
  assign pop_ok   = pop_re && rx_cnt != '0;
  assign rx_full  = rx_cnt == FULL;
  assign rx_in    = hold_q ? pop_ok : (rx_done && (!rx_full || pop_ok));
  assign hold_set = !hold_q && rx_done && rx_full && !pop_ok;
  assign rx_wdata = hold_q ? hold_data : rx_data;
  assign rx_cnt_n = rx_cnt + CNT_W'(rx_in) - CNT_W'(pop_ok);
  assign tx_head  = tx_mem[tx_nxt_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tx_mem[i] <= '0;
      tx_wr_ptr  <= '0;
      tx_nxt_ptr <= '0;
      tx_cnt     <= '0;
    end else begin
      if (push_ok) begin
        tx_mem[tx_wr_ptr] <= push_data;
        tx_wr_ptr <= nxt(tx_wr_ptr);
      end
      if (load_ok) tx_nxt_ptr <= nxt(tx_nxt_ptr);
      tx_cnt <= tx_cnt + CNT_W'(push_ok) - CNT_W'(load_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rx_mem[i] <= '0;
      rx_wr_ptr  <= '0;
      rx_pop_ptr <= '0;
      rx_cnt     <= '0;
      pop_data   <= '0;
      hold_q     <= 1'b0;
      hold_data  <= '0;
    end else begin
      if (pop_ok) begin
        pop_data   <= rx_mem[rx_pop_ptr];
        rx_pop_ptr <= nxt(rx_pop_ptr);
      end
      if (rx_in) begin
        rx_mem[rx_wr_ptr] <= rx_wdata;
        rx_wr_ptr <= nxt(rx_wr_ptr);
      end
      if (hold_set) begin
        hold_q    <= 1'b1;
        hold_data <= rx_data;
      end else if (hold_q && pop_ok) begin
        hold_q <= 1'b0;
      end
      rx_cnt <= rx_cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_flag <= 1'b0;
      ovf_flag   <= 1'b0;
      par_flag   <= 1'b0;
    end else begin
      if (rx_cnt_n != '0) drain_flag <= 1'b1;
      else if ((sts_we && sts_wdata[0]) || dma_ack) drain_flag <= 1'b0;

      if (xfer_start && rx_full && hold_q) ovf_flag <= 1'b1;
      else if (sts_we && sts_wdata[1]) ovf_flag <= 1'b0;

      if (rx_done && rx_parity_err) par_flag <= 1'b1;
      else if (sts_we && sts_wdata[2]) par_flag <= 1'b0;
    end
  end

  AST_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt == FULL && !tx_load |=> tx_cnt == FULL); // R1
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_re && rx_cnt == '0 |=> $stable(rx_pop_ptr) && $stable(pop_data)); // R4
  AST_RX_POP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && pop_re && rx_cnt != '0 && !hold_q |=> $stable(rx_cnt)); // R5
  AST_HELD_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && pop_re && rx_full |=> rx_cnt == FULL); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && rx_full && hold_q |=> ovf_flag); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(sts_we && sts_wdata[1]) |=> ovf_flag); // R7
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_flag && !(sts_we && sts_wdata[2]) |=> par_flag); // R8
  AST_DRAIN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt != '0 |-> drain_flag); // R9
endmodule

// File: tb/spi_fifo_status_tb.sv
module spi_fifo_status_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic push_we, tx_load, rx_done, rx_parity_err, xfer_start, pop_re, sts_we, dma_ack;
  logic [31:0] push_data, rx_data;
  logic [2:0]  sts_wdata;
  logic [31:0] tx_head, pop_data;
  logic [2:0]  tx_cnt, rx_cnt;
  logic [1:0]  tx_nxt_ptr, rx_pop_ptr;
  logic drain_flag, ovf_flag, par_flag;

  spi_fifo_status dut_i (
    .clk(clk), .rst_n(rst_n), .push_we(push_we), .push_data(push_data),
    .tx_load(tx_load), .tx_head(tx_head), .rx_done(rx_done), .rx_data(rx_data),
    .rx_parity_err(rx_parity_err), .xfer_start(xfer_start), .pop_re(pop_re),
    .pop_data(pop_data), .sts_we(sts_we), .sts_wdata(sts_wdata), .dma_ack(dma_ack),
    .tx_cnt(tx_cnt), .tx_nxt_ptr(tx_nxt_ptr), .rx_cnt(rx_cnt), .rx_pop_ptr(rx_pop_ptr),
    .drain_flag(drain_flag), .ovf_flag(ovf_flag), .par_flag(par_flag));

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_tx [4], m_rx [4];
  int m_txw, m_txr, m_txn, m_rxw, m_rxr, m_rxn;
  logic [31:0] m_pop, m_hdata;
  bit m_hold, m_drain, m_ovf, m_par;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int inc4(input int p);
    return (p + 1) % 4;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_tx[i] = '0; m_rx[i] = '0; end
    m_txw = 0; m_txr = 0; m_txn = 0; m_rxw = 0; m_rxr = 0; m_rxn = 0;
    m_pop = '0; m_hdata = '0; m_hold = 0; m_drain = 0; m_ovf = 0; m_par = 0;
  endtask

  task automatic model_step();
    bit push_ok, load_ok, pop_ok, in_ok, ovf_set;
    push_ok = push_we && m_txn != 4;
    load_ok = tx_load && m_txn != 0;
    if (push_ok) begin m_tx[m_txw] = push_data; m_txw = inc4(m_txw); end
    if (load_ok) m_txr = inc4(m_txr);
    m_txn = m_txn + int'(push_ok) - int'(load_ok);
    pop_ok  = pop_re && m_rxn != 0;
    ovf_set = xfer_start && m_rxn == 4 && m_hold;
    in_ok = 0;
    if (pop_ok) begin m_pop = m_rx[m_rxr]; m_rxr = inc4(m_rxr); end
    if (m_hold) begin
      if (pop_ok) begin m_rx[m_rxw] = m_hdata; m_rxw = inc4(m_rxw); m_hold = 0; in_ok = 1; end
    end else if (rx_done) begin
      if (m_rxn != 4 || pop_ok) begin m_rx[m_rxw] = rx_data; m_rxw = inc4(m_rxw); in_ok = 1; end
      else begin m_hold = 1; m_hdata = rx_data; end
    end
    m_rxn = m_rxn + int'(in_ok) - int'(pop_ok);
    if (m_rxn != 0) m_drain = 1;
    else if ((sts_we && sts_wdata[0]) || dma_ack) m_drain = 0;
    if (ovf_set) m_ovf = 1; else if (sts_we && sts_wdata[1]) m_ovf = 0;
    if (rx_done && rx_parity_err) m_par = 1; else if (sts_we && sts_wdata[2]) m_par = 0;
  endtask

  task automatic compare_all();
    chk("R1", "tx_cnt", 32'(tx_cnt), 32'(m_txn));
    chk("R2", "tx_nxt_ptr", 32'(tx_nxt_ptr), 32'(m_txr));
    chk("R2", "tx_head", tx_head, m_tx[m_txr]);
    chk("R3", "rx_cnt", 32'(rx_cnt), 32'(m_rxn));
    chk("R4", "rx_pop_ptr", 32'(rx_pop_ptr), 32'(m_rxr));
    chk("R4", "pop_data", pop_data, m_pop);
    chk("R7", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
    chk("R8", "par_flag", 32'(par_flag), 32'(m_par));
    chk("R9", "drain_flag", 32'(drain_flag), 32'(m_drain));
  endtask

  task automatic idle_inputs();
    push_we = 0; tx_load = 0; rx_done = 0; rx_parity_err = 0; xfer_start = 0;
    pop_re = 0; sts_we = 0; dma_ack = 0; push_data = '0; rx_data = '0; sts_wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    compare_all();
    idle_inputs();
  endtask

  task automatic do_push(input logic [31:0] d);
    push_we = 1; push_data = d; tick();
  endtask
  task automatic do_rx(input logic [31:0] d, input logic pe);
    rx_done = 1; rx_data = d; rx_parity_err = pe; tick();
  endtask
  task automatic do_pop();
    pop_re = 1; tick();
  endtask
  task automatic do_clr(input logic [2:0] b);
    sts_we = 1; sts_wdata = b; tick();
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "tx_cnt", 32'(tx_cnt), 0);
    chk("R10", "rx_cnt", 32'(rx_cnt), 0);
    chk("R10", "ptrs", {28'd0, tx_nxt_ptr, rx_pop_ptr}, 0);
    chk("R10", "flags", {29'd0, drain_flag, ovf_flag, par_flag}, 0);
    chk("R10", "data", tx_head | pop_data, 0);

    // R1 fill and overfill transmit FIFO
    for (int i = 0; i < 5; i++) do_push(32'hA000_0000 + 32'(i));
    chk("R1", "tx_cnt full", 32'(tx_cnt), 4);
    // R2 drain in order, then load on empty
    for (int i = 0; i < 4; i++) begin
      chk("R2", "tx_head order", tx_head, 32'hA000_0000 + 32'(i));
      tx_load = 1; tick();
    end
    tx_load = 1; tick();
    chk("R2", "tx empty load", {29'd0, tx_cnt}, 0);
    push_we = 1; push_data = 32'h55; tick();
    push_we = 1; push_data = 32'h66; tx_load = 1; tick();
    chk("R2", "push+load count", {29'd0, tx_cnt}, 1);

    // R3, R6, R7 receive overfill and overflow
    for (int i = 0; i < 4; i++) do_rx(32'hB000_0000 + 32'(i), 0);
    chk("R3", "rx_cnt full", 32'(rx_cnt), 4);
    do_rx(32'hB000_0004, 0);
    do_rx(32'hB000_0005, 0);
    xfer_start = 1; tick();
    chk("R7", "ovf set", 32'(ovf_flag), 1);
    do_pop();
    chk("R6", "count after held refill", 32'(rx_cnt), 4);
    chk("R4", "first pop", pop_data, 32'hB000_0000);
    for (int i = 0; i < 4; i++) do_pop();
    chk("R6", "held word popped", pop_data, 32'hB000_0004);
    do_pop();
    chk("R4", "empty pop data", pop_data, 32'hB000_0004);
    chk("R9", "drain stays", 32'(drain_flag), 1);
    do_clr(3'b001);
    chk("R9", "drain w1c", 32'(drain_flag), 0);
    do_clr(3'b010);
    chk("R7", "ovf w1c", 32'(ovf_flag), 0);

    // R5 simultaneous receive and pop
    do_rx(32'hC1, 0); do_rx(32'hC2, 1);
    chk("R8", "par set", 32'(par_flag), 1);
    rx_done = 1; rx_data = 32'hC3; pop_re = 1; tick();
    chk("R5", "rx_cnt same", 32'(rx_cnt), 2);
    do_clr(3'b001);
    chk("R9", "clear ignored nonempty", 32'(drain_flag), 1);
    do_pop(); do_pop();
    dma_ack = 1; tick();
    chk("R9", "dma clears", 32'(drain_flag), 0);
    do_clr(3'b100);
    chk("R8", "par w1c", 32'(par_flag), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      push_we = ($urandom % 3) == 0;  push_data = $urandom;
      tx_load = ($urandom % 3) == 0;
      rx_done = ($urandom % 3) == 0;  rx_data = $urandom;
      rx_parity_err = ($urandom % 8) == 0;
      xfer_start = ($urandom % 4) == 0;
      pop_re = ($urandom % ((n / 500) % 2 == 0 ? 2 : 5)) == 0;
      sts_we = ($urandom % 10) == 0;  sts_wdata = 3'($urandom);
      dma_ack = ($urandom % 12) == 0;
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule